// File: doc/BRIEF.md
# ADC Channel Group Trigger Controller

This block decides which of several channel-group slots drives a shared analog-to-digital converter, and when. Every slot stores a channel number, an interrupt enable, the latest result and a conversion-complete flag. Only one slot owns the converter at a time. The block launches conversions, cancels a conversion when its owning slot is rewritten, and records completions into the owning slot.

Two trigger sources exist. In software mode, writing slot 0 launches a conversion. In hardware mode, a pulse on one of the per-slot trigger lines launches that slot. A continuous bit makes the owning slot restart as soon as it finishes. The converter is a fixed-latency model inside the block, so results are deterministic.

Top module: `adc_grp_ctrl`

## Requirements
- R1: After reset all complete flags, `irq`, `active` and `rd_data` are 0.
- R2: In software mode (`hw_mode` = 0), a write to group 0 (`wr_grp` = 0) starts a conversion of the written channel. `active` is high from the cycle after the write for CONV_LAT cycles. Then `coco[0]` sets and group 0's result becomes (channel*37+5) mod 2^RES_W.
- R3: In software mode, writes to groups 1 and above and all `hw_trig` pulses start nothing.
- R4: In hardware mode (`hw_mode` = 1), a pulse on `hw_trig[n]` while the converter is idle starts group n with group n's stored channel. When several bits are set together, the lowest index wins. Writes to group 0 start nothing in this mode.
- R5: A trigger that arrives while a conversion is active is ignored and is not remembered.
- R6: Writing a group other than the one converting leaves the running conversion's timing and result untouched.
- R7: Writing the group that is converting aborts it: `active` drops, no complete flag is set and the stored result is unchanged. In software mode the same write to group 0 then restarts with the new channel, and the full latency counts from that write.
- R8: A write to the converting group on the cycle its conversion would finish still aborts it, and no flag is set.
- R9: `irq` is high exactly when some group has both its complete flag and its interrupt enable set.
- R10: `rd_data` shows the result of group `rd_grp` in the same cycle. A read with `rd_en` clears that group's complete flag, but a completion into the same group in the same cycle leaves the flag set.
- R11: With `cont_mode` = 1, a finishing group restarts at once and `active` stays high. This continues until `cont_mode` is 0 at a completion or the group is rewritten.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_mode | input | 1 | 0 = software trigger, 1 = hardware trigger |
| cont_mode | input | 1 | Continuous restart enable |
| wr_en | input | 1 | Group register write strobe |
| wr_grp | input | GI_W | Group index for the write |
| wr_chan | input | CH_W | Channel number written |
| wr_ie | input | 1 | Interrupt enable written |
| hw_trig | input | NUM_GRP | Per-group hardware trigger pulses |
| rd_en | input | 1 | Result read strobe, clears the complete flag |
| rd_grp | input | GI_W | Group index for the read |
| rd_data | output | RES_W | Result of group `rd_grp` |
| coco | output | NUM_GRP | Per-group conversion-complete flags |
| irq | output | 1 | Interrupt request |
| active | output | 1 | A conversion is in progress |

## Verification
Two pairs of events can coincide on the edge where a conversion finishes. One is a rewrite of the owning group, which must abort the conversion and leave no flag. The other is a result read of that group, where the flag must survive because the new completion outranks the clear. The bench counts cycles from the start edge so that the write or the read lands exactly on edge CONV_LAT. It then judges the outcome from `coco`, `active` and a later read of `rd_data`.

// File: rtl/adc_grp_pkg.sv
package adc_grp_pkg;

    typedef enum logic {
        TRIG_SW = 1'b0,
        TRIG_HW = 1'b1
    } trig_mode_e;

    localparam int unsigned CODE_MUL = 37;
    localparam int unsigned CODE_ADD = 5;

    // Deterministic stand-in for the analog value seen on a channel
    function automatic int unsigned conv_code(input int unsigned chan);
        return chan * CODE_MUL + CODE_ADD;
    endfunction

endpackage

// File: rtl/adc_conv_model.sv
module adc_conv_model
    import adc_grp_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int RES_W = 12,
    parameter int LAT   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [CH_W-1:0]  chan_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] data_o
);
    localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0]  chan;
    } conv_st_t;

    conv_st_t st_d, st_q;

    assign busy_o = st_q.busy;
    assign done_o = st_q.busy && (st_q.cnt == '0);
    assign data_o = RES_W'(conv_code(32'(st_q.chan)));

    always_comb begin
        st_d = st_q;
        if (abort_i) begin
            st_d.busy = 1'b0;
        end
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(LAT - 1);
            st_d.chan = chan_i;
        end else if (done_o) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy && !abort_i) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: an abort with no restart leaves the converter idle
    a_r7_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i && !start_i |=> !busy_o);

    // R2: a running conversion keeps going until it finishes or is cut
    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o && !abort_i |=> busy_o);

endmodule

// File: rtl/adc_grp_seq.sv
module adc_grp_seq
    import adc_grp_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int CH_W    = 5,
    parameter int GI_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hw_mode_i,
    input  logic                           cont_i,
    input  logic                           wr_en_i,
    input  logic [GI_W-1:0]                wr_grp_i,
    input  logic [CH_W-1:0]                wr_chan_i,
    input  logic [NUM_GRP-1:0]             hw_trig_i,
    input  logic [NUM_GRP-1:0][CH_W-1:0]   chan_tab_i,
    input  logic                           conv_busy_i,
    input  logic                           conv_done_i,
    output logic                           start_o,
    output logic                           abort_o,
    output logic [CH_W-1:0]                start_chan_o,
    output logic                           cmpl_o,
    output logic [GI_W-1:0]                cmpl_grp_o
);
    typedef struct packed {
        logic [GI_W-1:0] act_grp;
    } seq_st_t;

    seq_st_t         st_d, st_q;
    trig_mode_e      mode;
    logic            hw_hit;
    logic [GI_W-1:0] hw_sel;
    logic            sw_start, hw_start, cont_start;

    assign mode = trig_mode_e'(hw_mode_i);

    // Lowest-index hardware trigger wins
    always_comb begin
        hw_hit = 1'b0;
        hw_sel = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (hw_trig_i[g]) begin
                hw_hit = 1'b1;
                hw_sel = GI_W'(g);
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        abort_o    = conv_busy_i && wr_en_i && (wr_grp_i == st_q.act_grp);
        cmpl_o     = conv_done_i && !abort_o;
        cmpl_grp_o = st_q.act_grp;

        sw_start   = (mode == TRIG_SW) && wr_en_i && (wr_grp_i == '0)
                     && (!conv_busy_i || abort_o);
        cont_start = cmpl_o && cont_i;
        hw_start   = (mode == TRIG_HW) && !conv_busy_i && hw_hit;

        start_o      = 1'b0;
        start_chan_o = '0;
        if (sw_start) begin
            start_o      = 1'b1;
            start_chan_o = wr_chan_i;
            st_d.act_grp = '0;
        end else if (cont_start) begin
            start_o      = 1'b1;
            start_chan_o = chan_tab_i[st_q.act_grp];
        end else if (hw_start) begin
            start_o      = 1'b1;
            start_chan_o = (wr_en_i && wr_grp_i == hw_sel) ? wr_chan_i
                                                            : chan_tab_i[hw_sel];
            st_d.act_grp = hw_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: nothing starts while a conversion runs on undisturbed
    a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy_i && !abort_o && !conv_done_i |-> !start_o);

    // R3: in software mode only a group-0 write (or a continuous restart) starts
    a_r3_sw_only_g0: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && !hw_mode_i && !(conv_done_i && cont_i)
        |-> wr_en_i && (wr_grp_i == '0));

    // R2: a start makes the converter busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> conv_busy_i);

endmodule

// File: rtl/adc_grp_bank.sv
module adc_grp_bank #(
    parameter int NUM_GRP = 4,
    parameter int CH_W    = 5,
    parameter int RES_W   = 12,
    parameter int GI_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [GI_W-1:0]               wr_grp_i,
    input  logic [CH_W-1:0]               wr_chan_i,
    input  logic                          wr_ie_i,
    input  logic                          rd_en_i,
    input  logic [GI_W-1:0]               rd_grp_i,
    input  logic                          cmpl_i,
    input  logic [GI_W-1:0]               cmpl_grp_i,
    input  logic [RES_W-1:0]              cmpl_data_i,
    output logic [NUM_GRP-1:0][CH_W-1:0]  chan_tab_o,
    output logic [NUM_GRP-1:0]            ie_o,
    output logic [NUM_GRP-1:0]            coco_o,
    output logic [RES_W-1:0]              rd_data_o
);
    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic             ie;
        logic             coco;
        logic [RES_W-1:0] res;
    } grp_t;

    logic [NUM_GRP-1:0][RES_W-1:0] res_tab;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        grp_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en_i && wr_grp_i == GI_W'(g)) begin
                slot_d.chan = wr_chan_i;
                slot_d.ie   = wr_ie_i;
            end
            if (rd_en_i && rd_grp_i == GI_W'(g)) begin
                slot_d.coco = 1'b0;
            end
            // A completion outranks a same-cycle clear
            if (cmpl_i && cmpl_grp_i == GI_W'(g)) begin
                slot_d.coco = 1'b1;
                slot_d.res  = cmpl_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign chan_tab_o[g] = slot_q.chan;
        assign ie_o[g]       = slot_q.ie;
        assign coco_o[g]     = slot_q.coco;
        assign res_tab[g]    = slot_q.res;
    end

    assign rd_data_o = res_tab[rd_grp_i];

    // R10: a read with no competing completion leaves the flag clear
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && !(cmpl_i && cmpl_grp_i == rd_grp_i)
        |=> !coco_o[$past(rd_grp_i)]);

    // R6: only one group can gain a complete flag per cycle
    a_r6_single_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coco_o & ~$past(coco_o)) <= 1);

endmodule

// File: rtl/adc_grp_ctrl.sv
module adc_grp_ctrl #(
    parameter int NUM_GRP  = 4,
    parameter int CH_W     = 5,
    parameter int RES_W    = 12,
    parameter int CONV_LAT = 8,
    localparam int GI_W    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_mode,
    input  logic               cont_mode,
    input  logic               wr_en,
    input  logic [GI_W-1:0]    wr_grp,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic               wr_ie,
    input  logic [NUM_GRP-1:0] hw_trig,
    input  logic               rd_en,
    input  logic [GI_W-1:0]    rd_grp,
    output logic [RES_W-1:0]   rd_data,
    output logic [NUM_GRP-1:0] coco,
    output logic               irq,
    output logic               active
);
    logic [NUM_GRP-1:0][CH_W-1:0] chan_tab;
    logic [NUM_GRP-1:0]           ie_vec;
    logic                         start, abort, cmpl;
    logic [CH_W-1:0]              start_chan;
    logic [GI_W-1:0]              cmpl_grp;
    logic                         conv_busy, conv_done;
    logic [RES_W-1:0]             conv_data;

    adc_grp_seq #(
        .NUM_GRP(NUM_GRP), .CH_W(CH_W), .GI_W(GI_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .hw_mode_i(hw_mode), .cont_i(cont_mode),
        .wr_en_i(wr_en), .wr_grp_i(wr_grp), .wr_chan_i(wr_chan),
        .hw_trig_i(hw_trig), .chan_tab_i(chan_tab),
        .conv_busy_i(conv_busy), .conv_done_i(conv_done),
        .start_o(start), .abort_o(abort), .start_chan_o(start_chan),
        .cmpl_o(cmpl), .cmpl_grp_o(cmpl_grp)
    );

    adc_conv_model #(
        .CH_W(CH_W), .RES_W(RES_W), .LAT(CONV_LAT)
    ) conv_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .abort_i(abort), .chan_i(start_chan),
        .busy_o(conv_busy), .done_o(conv_done), .data_o(conv_data)
    );

    adc_grp_bank #(
        .NUM_GRP(NUM_GRP), .CH_W(CH_W), .RES_W(RES_W), .GI_W(GI_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_grp_i(wr_grp), .wr_chan_i(wr_chan), .wr_ie_i(wr_ie),
        .rd_en_i(rd_en), .rd_grp_i(rd_grp),
        .cmpl_i(cmpl), .cmpl_grp_i(cmpl_grp), .cmpl_data_i(conv_data),
        .chan_tab_o(chan_tab), .ie_o(ie_vec), .coco_o(coco), .rd_data_o(rd_data)
    );

    assign irq    = |(coco & ie_vec);
    assign active = conv_busy;

    // R8: an abort on the finishing edge leaves the owning flag as it was
    a_r8_abort_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> coco[$past(cmpl_grp)] == $past(coco[cmpl_grp]) || $past(rd_en));

endmodule

// File: tb/adc_grp_ctrl_tb_top.sv
module adc_grp_ctrl_tb_top;
    localparam int LAT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_mode = 1'b0, cont_mode = 1'b0;
    logic       wr_en = 1'b0, wr_ie = 1'b0;
    logic [1:0] wr_grp = '0;
    logic [4:0] wr_chan = '0;
    logic [3:0] hw_trig = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_grp = '0;
    logic [11:0] rd_data;
    logic [3:0] coco;
    logic       irq, active;

    int n_chk = 0, n_err = 0;
    bit fin = 1'b0;

    always #10 clk = ~clk;

    adc_grp_ctrl #(.NUM_GRP(4), .CH_W(5), .RES_W(12), .CONV_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .cont_mode(cont_mode),
        .wr_en(wr_en), .wr_grp(wr_grp), .wr_chan(wr_chan), .wr_ie(wr_ie),
        .hw_trig(hw_trig), .rd_en(rd_en), .rd_grp(rd_grp), .rd_data(rd_data),
        .coco(coco), .irq(irq), .active(active)
    );

    localparam int NV = 6;
    localparam int V_CH  [NV] = '{0, 31, 7, 18, 1, 25};
    localparam bit V_IE  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam int V_RES [NV] = '{5, 1152, 264, 671, 42, 930};

    function automatic int code(input int ch);
        return (ch * 37 + 5) % 4096;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input int g, input int ch, input bit ie);
        @(negedge clk);
        wr_en = 1'b1; wr_grp = 2'(g); wr_chan = 5'(ch); wr_ie = ie;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        hw_trig = m;
        @(negedge clk);
        hw_trig = '0;
    endtask

    task automatic do_rd(input int g, output int val);
        @(negedge clk);
        rd_en = 1'b1; rd_grp = 2'(g);
        #1 val = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk("R1 coco", coco, 0);
        chk("R1 irq", irq, 0);
        chk("R1 active", active, 0);
        chk("R1 rd_data", rd_data, 0);

        // Vector table: software conversions on group 0 (R2, R9, R10)
        for (int i = 0; i < NV; i++) begin
            do_wr(0, V_CH[i], V_IE[i]);
            wait_n(LAT - 1);
            chk("R2 active during", active, 1);
            chk("R2 flag not yet", coco[0], 0);
            wait_n(1);
            chk("R2 flag set", coco[0], 1);
            chk("R2 active drops", active, 0);
            chk("R9 irq", irq, V_IE[i]);
            do_rd(0, v);
            chk("R2 result", v, V_RES[i]);
            chk("R10 read clears", coco[0], 0);
            chk("R9 irq after clear", irq, 0);
        end

        // R3: software mode ignores other groups and hw triggers
        do_wr(1, 5, 1'b1);
        chk("R3 write g1 no start", active, 0);
        pulse(4'b0010);
        chk("R3 trigger no start", active, 0);
        wait_n(LAT + 1);
        chk("R3 no flag", coco, 0);

        // R4: hardware mode, lowest trigger wins
        hw_mode = 1'b1;
        do_wr(0, 4, 1'b0);
        chk("R4 write g0 no start", active, 0);
        do_wr(1, 3, 1'b1);
        do_wr(2, 9, 1'b0);
        do_wr(3, 20, 1'b0);
        pulse(4'b0110);
        wait_n(LAT - 1);
        chk("R4 active", active, 1);
        wait_n(1);
        chk("R4 only g1 flag", coco, 4'b0010);
        chk("R9 irq g1", irq, 1);
        do_rd(1, v);
        chk("R4 g1 result", v, code(3));

        // R5: trigger during a conversion is dropped
        pulse(4'b0100);
        wait_n(2);
        pulse(4'b1000);
        wait_n(LAT - 5);
        chk("R5 active", active, 1);
        wait_n(1);
        chk("R5 flag g2 only", coco, 4'b0100);
        chk("R5 idle after", active, 0);
        wait_n(LAT + 1);
        chk("R5 g3 never ran", coco, 4'b0100);
        do_rd(2, v);
        chk("R5 g2 result", v, code(9));

        // R6: writing an idle group mid-conversion
        pulse(4'b0100);
        wait_n(1);
        do_wr(3, 21, 1'b1);
        wait_n(LAT - 4);
        chk("R6 still active", active, 1);
        wait_n(1);
        chk("R6 g2 flag on time", coco, 4'b0100);
        do_rd(2, v);
        chk("R6 g2 result", v, code(9));
        pulse(4'b1000);
        wait_n(LAT);
        chk("R6 g3 new channel flag", coco[3], 1);
        do_rd(3, v);
        chk("R6 g3 new channel result", v, code(21));

        // R7: hardware abort by rewriting the active group
        pulse(4'b0010);
        wait_n(2);
        do_wr(1, 6, 1'b0);
        chk("R7 abort drops active", active, 0);
        wait_n(LAT);
        chk("R7 no flag", coco[1], 0);
        do_rd(1, v);
        chk("R7 result kept", v, code(3));

        // R8: rewrite lands on the finishing edge
        pulse(4'b0100);
        wait_n(LAT - 2);
        do_wr(2, 11, 1'b0);
        chk("R8 no flag", coco[2], 0);
        chk("R8 idle", active, 0);
        wait_n(2);
        chk("R8 still no flag", coco[2], 0);
        do_rd(2, v);
        chk("R8 result kept", v, code(9));

        // R7: software restart by rewriting group 0
        hw_mode = 1'b0;
        do_wr(0, 10, 1'b0);
        wait_n(2);
        do_wr(0, 12, 1'b0);
        wait_n(LAT - 1);
        chk("R7 sw restart no early flag", coco[0], 0);
        chk("R7 sw restart active", active, 1);
        wait_n(1);
        chk("R7 sw restart flag", coco[0], 1);
        do_rd(0, v);
        chk("R7 sw restart result", v, code(12));

        // R10: read on the completion edge keeps the flag
        do_wr(0, 2, 1'b0);
        wait_n(LAT - 2);
        do_rd(0, v);
        chk("R10 old result visible", v, code(12));
        chk("R10 flag survives", coco[0], 1);
        do_rd(0, v);
        chk("R10 new result", v, code(2));
        chk("R10 cleared", coco[0], 0);

        // R11: continuous restart
        cont_mode = 1'b1;
        do_wr(0, 7, 1'b0);
        wait_n(LAT);
        chk("R11 first flag", coco[0], 1);
        chk("R11 active kept", active, 1);
        do_rd(0, v);
        chk("R11 first result", v, code(7));
        wait_n(LAT - 3);
        chk("R11 between", coco[0], 0);
        wait_n(1);
        chk("R11 second flag", coco[0], 1);
        chk("R11 still active", active, 1);
        @(negedge clk);
        cont_mode = 1'b0;
        wait_n(LAT - 1);
        chk("R11 stops when cleared", active, 0);
        wait_n(LAT);
        chk("R11 stays idle", active, 0);
        do_rd(0, v);

        // R11: rewrite stops a continuous hardware group
        hw_mode = 1'b1;
        cont_mode = 1'b1;
        pulse(4'b1000);
        wait_n(2);
        do_wr(3, 21, 1'b1);
        chk("R11 rewrite stops", active, 0);
        wait_n(2 * LAT);
        chk("R11 rewrite stays idle", active, 0);
        chk("R11 rewrite no flag", coco[3], 0);
        cont_mode = 1'b0;

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule